// File: doc/BRIEF.md
# Blanking-Aware Wide Horizontal Clock Generator

This block generates the two complementary horizontal shift-clock phases that drive a CCD's horizontal register. Phase A feeds the first and third shift gates and phase B feeds the second and fourth. The block runs on a clock at twice the pixel rate. Outside the horizontal blanking area each phase toggles on every edge of that clock, so the shift clocks run at the pixel rate.

Inside the blanking area the shift clocks can be slowed down. This lets blanking patterns perform charge mixing in the sensor. The slowing is set by a 4-bit width field N, carried in bits 7:4 of an 8-bit control word. A nonzero N divides the shift-clock frequency by 2N, so each half-period lasts N pixel periods (2N cycles of the block clock). Slowing applies only when the blanking mode in force is 0 or 1. Mode 2, and the unused code 3, keep the pixel rate.

The width and the mode are captured once, on the clock edge where blanking is first seen. Changes made during an interval therefore take effect only at the next interval. When blanking ends, the phases go back to pixel-rate toggling at once. Every change of the outputs comes from a single register, so no glitch can appear.

A three-state controller holds the sequencing:

- **PIXEL** is the normal state. It toggles every cycle.
- **BLANK_PLAIN** covers a blanking interval with slowing off. It also toggles every cycle.
- **BLANK_WIDE** covers a blanking interval with slowing on. It toggles only when the half-period counter reaches its stored limit.

The transitions are:

- **ENTER_WIDE**: PIXEL to BLANK_WIDE, when blanking is seen, N is not 0 and the mode is 0 or 1.
- **ENTER_PLAIN**: PIXEL to BLANK_PLAIN, when blanking is seen and slowing is not allowed.
- **LEAVE_PLAIN**: BLANK_PLAIN to PIXEL, when blanking drops.
- **LEAVE_WIDE**: BLANK_WIDE to PIXEL, when blanking drops.

Top module: `hclk_wide_gen`

## Requirements
- R1: While rst_ni is low, hc_a_o is 0 and hc_b_o is 1, and the controller is in PIXEL.
- R2: In every cycle, hc_b_o is the inverse of hc_a_o.
- R3: Outside blanking, hc_a_o toggles on every rising edge of clk_i. "Outside blanking" means the controller is in PIXEL and blank_i is sampled low.
- R4: If the width field ctrl_i[7:4] is 0 at the edge where blanking is first sampled, hc_a_o keeps toggling on every edge for the whole interval.
- R5: If ctrl_i[7:4] = N is in 1..15 and mode_i is 0 or 1 at the entry edge, hc_a_o toggles at the entry edge. It then toggles once every 2N edges for as long as blank_i stays high, giving 1/(2N) of the pixel rate.
- R6: If mode_i is 2 or 3 at the entry edge, slowing is suppressed for that interval and hc_a_o toggles on every edge.
- R7: Changes to ctrl_i during a blanking interval have no effect on that interval's half-period, and ctrl_i[3:0] never has any effect.
- R8: At the first edge where blank_i is sampled low after a slowed interval, hc_a_o toggles and pixel-rate toggling resumes. This holds even when that edge coincides with the end of a slowed half-period.
- R9: Changes to mode_i during a blanking interval have no effect on that interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, twice the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blank_i | input | 1 | High while inside the horizontal blanking area |
| mode_i | input | 2 | Blanking mode; 0 and 1 allow slowing, 2 and 3 suppress it |
| ctrl_i | input | 8 | Control word; bits 7:4 hold the width field N |
| hc_a_o | output | 1 | Shift-clock phase A (first/third gates) |
| hc_b_o | output | 1 | Shift-clock phase B (second/fourth gates), complement of A |

## Verification
The end of blanking and the terminal count of a slowed half-period can fall on the same edge. Both call for a toggle, so a wrong priority would produce either a double toggle, which is no change, or a missing one. The bench provokes this by holding blank_i high for exactly 2N cycles, and also for 2N±1 cycles. A behavioural reference model, which counts down from 2N, judges every cycle's phase. Entry into blanking one cycle after an exit is also exercised, so that capturing a new width overlaps the first pixel-rate toggle.

// File: rtl/hclkw_pkg.sv
package hclkw_pkg;

    typedef enum logic [1:0] {
        ST_PIXEL       = 2'd0,
        ST_BLANK_PLAIN = 2'd1,
        ST_BLANK_WIDE  = 2'd2
    } hclkw_state_e;

endpackage

// File: rtl/hclkw_cfg.sv
module hclkw_cfg #(
    parameter int CTRL_W  = 8,
    parameter int WID_LSB = 4,
    parameter int WID_W   = 4,
    parameter int MODE_W  = 2,
    parameter int CNT_W   = WID_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              widen_ok_o,
    output logic [CNT_W-1:0]  lim_o
);
    localparam logic [MODE_W-1:0] FIRST_NO_WIDE_MODE = MODE_W'(2);

    logic [WID_W-1:0] width_w;
    logic             mode_ok_w;
    logic [CNT_W-1:0] lim_q;

    assign width_w    = ctrl_i[WID_LSB +: WID_W];
    assign mode_ok_w  = (mode_i < FIRST_NO_WIDE_MODE);
    assign widen_ok_o = mode_ok_w && (width_w != '0);

    // the stored limit is the last count of a half-period: 2N-1
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lim_q <= '0;
        end else if (load_i) begin
            lim_q <= {width_w, 1'b0} - CNT_W'(1);
        end
    end

    assign lim_o = lim_q;

endmodule

// File: rtl/hclkw_half_cnt.sv
module hclkw_half_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (cnt_q == lim_i) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign done_o = (cnt_q == lim_i);

    // R5
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q <= lim_i));

endmodule

// File: rtl/hclkw_fsm.sv
module hclkw_fsm
    import hclkw_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         blank_i,
    input  logic         widen_ok_i,
    input  logic         done_i,
    output hclkw_state_e state_o,
    output logic         load_o,
    output logic         clr_o,
    output logic         run_o,
    output logic         toggle_o
);
    hclkw_state_e state_q;
    hclkw_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_PIXEL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load_o   = 1'b0;
        clr_o    = 1'b0;
        run_o    = 1'b0;
        toggle_o = 1'b0;
        unique case (state_q)
            ST_PIXEL: begin
                toggle_o = 1'b1;
                if (blank_i) begin
                    load_o = 1'b1;
                    if (widen_ok_i) begin
                        clr_o   = 1'b1;
                        state_d = ST_BLANK_WIDE;    // ENTER_WIDE
                    end else begin
                        state_d = ST_BLANK_PLAIN;   // ENTER_PLAIN
                    end
                end
            end
            ST_BLANK_PLAIN: begin
                toggle_o = 1'b1;
                if (!blank_i) begin
                    state_d = ST_PIXEL;             // LEAVE_PLAIN
                end
            end
            ST_BLANK_WIDE: begin
                if (!blank_i) begin
                    toggle_o = 1'b1;                // exit wins over terminal count
                    state_d  = ST_PIXEL;            // LEAVE_WIDE
                end else begin
                    run_o    = 1'b1;
                    toggle_o = done_i;
                end
            end
            default: begin
                state_d = ST_PIXEL;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/hclkw_phase.sv
module hclkw_phase (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic toggle_i,
    output logic ph_a_o,
    output logic ph_b_o
);
    logic ph_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q <= 1'b0;
        end else if (toggle_i) begin
            ph_q <= ~ph_q;
        end
    end

    assign ph_a_o = ph_q;
    assign ph_b_o = ~ph_q;

endmodule

// File: rtl/hclk_wide_gen.sv
module hclk_wide_gen
    import hclkw_pkg::*;
#(
    parameter int CTRL_W  = 8,
    parameter int WID_LSB = 4,
    parameter int WID_W   = 4,
    parameter int MODE_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              blank_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              hc_a_o,
    output logic              hc_b_o
);
    localparam int CNT_W = WID_W + 1;

    hclkw_state_e     state_w;
    logic             load_w;
    logic             clr_w;
    logic             run_w;
    logic             toggle_w;
    logic             widen_ok_w;
    logic             done_w;
    logic [CNT_W-1:0] lim_w;

    hclkw_cfg #(
        .CTRL_W  (CTRL_W),
        .WID_LSB (WID_LSB),
        .WID_W   (WID_W),
        .MODE_W  (MODE_W),
        .CNT_W   (CNT_W)
    ) cfg_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load_w),
        .ctrl_i     (ctrl_i),
        .mode_i     (mode_i),
        .widen_ok_o (widen_ok_w),
        .lim_o      (lim_w)
    );

    hclkw_half_cnt #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_w),
        .run_i  (run_w),
        .lim_i  (lim_w),
        .done_o (done_w)
    );

    hclkw_fsm fsm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .blank_i    (blank_i),
        .widen_ok_i (widen_ok_w),
        .done_i     (done_w),
        .state_o    (state_w),
        .load_o     (load_w),
        .clr_o      (clr_w),
        .run_o      (run_w),
        .toggle_o   (toggle_w)
    );

    hclkw_phase phase_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .toggle_i (toggle_w),
        .ph_a_o   (hc_a_o),
        .ph_b_o   (hc_b_o)
    );

    // R3
    pixel_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_PIXEL && !blank_i) |=> (hc_a_o != $past(hc_a_o)));

    // R4
    zero_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_PIXEL && blank_i && ctrl_i[WID_LSB +: WID_W] == '0)
        |=> (state_w == ST_BLANK_PLAIN));

    // R6
    mode_suppress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_PIXEL && blank_i && mode_i >= MODE_W'(2))
        |=> (state_w == ST_BLANK_PLAIN));

    // R5
    wide_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_BLANK_WIDE && blank_i && !done_w) |=> $stable(hc_a_o));

    // R7
    lim_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_BLANK_WIDE) |=> $stable(lim_w));

    // R8
    wide_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_BLANK_WIDE && !blank_i)
        |=> (state_w == ST_PIXEL && hc_a_o != $past(hc_a_o)));

endmodule

// File: tb/hclk_wide_gen_tb.sv
`timescale 1ns/1ps
module hclk_wide_gen_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       blank_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [7:0] ctrl_i = 8'h00;
    logic       hc_a_o;
    logic       hc_b_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference model state
    int m_ph = 0;
    int m_in = 0;
    int m_wide = 0;
    int m_len = 0;
    int m_left = 0;

    always #2 clk_i = ~clk_i;

    hclk_wide_gen dut_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .blank_i (blank_i),
        .mode_i  (mode_i),
        .ctrl_i  (ctrl_i),
        .hc_a_o  (hc_a_o),
        .hc_b_o  (hc_b_o)
    );

    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_ph = 0; m_in = 0; m_wide = 0; m_len = 0; m_left = 0;
        end else if (m_in == 0) begin
            m_ph = m_ph ^ 1;
            if (blank_i) begin
                int n;
                n = int'(ctrl_i[7:4]);
                m_in = 1;
                m_wide = (n != 0 && mode_i < 2) ? 1 : 0;
                m_len = 2 * n;
                m_left = m_len;
            end
        end else if (!blank_i) begin
            m_in = 0;
            m_ph = m_ph ^ 1;
        end else if (m_wide == 0) begin
            m_ph = m_ph ^ 1;
        end else begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                m_ph = m_ph ^ 1;
                m_left = m_len;
            end
        end
    end

    task automatic compare();
        n_cmp++;
        if (hc_a_o !== m_ph[0]) begin
            n_bad++;
            $display("FAIL %s: hc_a_o=%b expected %b at %0t", cur_req, hc_a_o, m_ph[0], $time);
        end
        n_cmp++;
        if (hc_b_o !== ~hc_a_o) begin
            n_bad++;
            $display("FAIL R2: hc_b_o=%b expected %b at %0t", hc_b_o, ~hc_a_o, $time);
        end
    endtask

    task automatic drive(input logic b, input logic [1:0] m, input logic [7:0] c, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            compare();
            blank_i = b;
            mode_i  = m;
            ctrl_i  = c;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset values
        cur_req = "R1";
        repeat (3) begin
            @(negedge clk_i);
            n_cmp++;
            if (hc_a_o !== 1'b0 || hc_b_o !== 1'b1) begin
                n_bad++;
                $display("FAIL R1: a=%b b=%b expected 0 1", hc_a_o, hc_b_o);
            end
        end
        rst_ni = 1'b1;

        cur_req = "R3";
        drive(1'b0, 2'd0, 8'h30, 10);

        cur_req = "R4";
        drive(1'b1, 2'd0, 8'h0F, 12);
        drive(1'b0, 2'd0, 8'h00, 4);

        cur_req = "R5";
        drive(1'b1, 2'd0, 8'h10, 20);
        drive(1'b0, 2'd0, 8'h10, 4);
        drive(1'b1, 2'd1, 8'h30, 30);
        drive(1'b0, 2'd1, 8'h30, 4);
        drive(1'b1, 2'd0, 8'hF0, 75);
        drive(1'b0, 2'd0, 8'hF0, 4);

        cur_req = "R6";
        drive(1'b1, 2'd2, 8'h50, 14);
        drive(1'b0, 2'd2, 8'h50, 3);
        drive(1'b1, 2'd3, 8'h50, 14);
        drive(1'b0, 2'd0, 8'h50, 3);

        cur_req = "R7";
        drive(1'b1, 2'd0, 8'h2A, 1);
        drive(1'b1, 2'd0, 8'h75, 6);
        drive(1'b1, 2'd0, 8'h7F, 14);
        drive(1'b0, 2'd0, 8'h7F, 3);

        cur_req = "R9";
        drive(1'b1, 2'd0, 8'h20, 2);
        drive(1'b1, 2'd2, 8'h20, 15);
        drive(1'b0, 2'd2, 8'h20, 3);

        cur_req = "R8";
        // blank high exactly 2N cycles: exit coincides with terminal count
        drive(1'b1, 2'd0, 8'h20, 4);
        drive(1'b0, 2'd0, 8'h20, 4);
        drive(1'b1, 2'd0, 8'h20, 5);
        drive(1'b0, 2'd0, 8'h20, 4);
        drive(1'b1, 2'd0, 8'h20, 3);
        drive(1'b0, 2'd0, 8'h20, 1);
        drive(1'b1, 2'd1, 8'h30, 6);
        drive(1'b0, 2'd1, 8'h30, 1);
        drive(1'b1, 2'd0, 8'h10, 2);
        drive(1'b0, 2'd0, 8'h10, 6);

        finish_run();
    end

endmodule